// File: doc/BRIEF.md
# Configurable Pad I/O Cell Bank

This block is a bank of pad-side cells. Each cell links one device pin to the internal logic, and each one is set up through its own configuration bits. On the input side, a cell passes the pin value straight through, or registers it on the rising edge of one of two I/O clock lines, or holds it in a level-sensitive latch. The latch is open while the chosen I/O clock line is high.

On the output side, a cell is one of three kinds: input-only, output-only, or bidirectional. A bidirectional cell takes its drive enable from one of two shared global output-enable inputs, or from an enable that the core logic generates. Every cell also chooses between a push-pull output and an open-drain output. In open-drain mode the cell only ever pulls the pin low. A configuration value of zero means push-pull, which is the default state of an erased part.

The pin itself is modelled as three signals: the value to drive, a drive enable, and the value sensed on the pin. A global active-low reset clears the input register and the input latch at once. Electrical strength, slew rate and voltage levels are not modelled.

Top module: `pio_cell_bank`

## Requirements
- R1: With input mode 0 or 3, core_di of a lane equals pad_in of that lane combinationally.
- R2: With input mode 1, core_di takes pad_in on the rising edge of the selected I/O clock, which is ioclk0 when clk_sel is 0 and ioclk1 when clk_sel is 1. Edges of the unselected clock leave core_di unchanged.
- R3: With input mode 2, core_di follows pad_in while the selected I/O clock is high. It holds the last value while that clock is low.
- R4: While rst_n is low, lanes in input mode 1 or 2 show core_di = 0. The clear takes effect without waiting for a clock edge, and a clock edge does not override it.
- R5: With direction 0 or 3 (input-only), pad_oe is 0.
- R6: With direction 1 (output-only), the internal enable is 1.
- R7: With direction 2 (bidirectional), the internal enable comes from the source field: 0 selects goe[0], 1 selects goe[1], and 2 or 3 selects core_oe of the lane.
- R8: With od = 0 (push-pull), pad_out equals core_do and pad_oe equals the internal enable.
- R9: With od = 1 (open-drain), pad_out is 0 and pad_oe is the internal enable AND NOT core_do, so the pad is never driven high.
- R10: The input path senses pad_in even while the same lane is driving the pad.
- R11: Each lane uses only its own 2-bit fields (lane i at bits [2i+1:2i]) and its own 1-bit fields (bit i). The setup of one lane does not affect any other lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ioclk0 | input | 1 | I/O clock line 0 |
| ioclk1 | input | 1 | I/O clock line 1 |
| rst_n | input | 1 | Global active-low reset of the input register and latch |
| goe | input | N_GOE | Global output enables, active high |
| cfg_in_mode | input | 2*N_CELLS | Input mode per lane: 0/3 direct, 1 registered, 2 latched |
| cfg_clk_sel | input | N_CELLS | I/O clock choice per lane |
| cfg_dir | input | 2*N_CELLS | Direction per lane: 0/3 input-only, 1 output-only, 2 bidirectional |
| cfg_oe_src | input | 2*N_CELLS | Enable source per lane for bidirectional mode |
| cfg_od | input | N_CELLS | 1 = open-drain, 0 = push-pull |
| core_do | input | N_CELLS | Data from the core to the pins |
| core_oe | input | N_CELLS | Enables generated by the core logic |
| core_di | output | N_CELLS | Captured pin data to the core |
| pad_in | input | N_CELLS | Value sensed on each pin |
| pad_out | output | N_CELLS | Value to drive on each pin |
| pad_oe | output | N_CELLS | Drive enable for each pin |

## Verification
A wrong enable source or a wrong direction decode shows up on pad_oe at once, in the same cycle that the configuration or the enable inputs change. The output sweep covers every combination of direction, enable source, drive type, global enables, data and core enable, so such a fault cannot hide. A wrong clock choice, a wrong edge or a bad latch window shows up on core_di at the first edge of either I/O clock after pad_in changes. A missing clear shows up half a nanosecond after rst_n falls.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [1:0] {
    IN_DIRECT   = 2'd0,
    IN_REG      = 2'd1,
    IN_LATCH    = 2'd2,
    IN_DIRECT_B = 2'd3
  } in_mode_e;

  typedef enum logic [1:0] {
    DIR_INPUT   = 2'd0,
    DIR_OUTPUT  = 2'd1,
    DIR_BIDIR   = 2'd2,
    DIR_INPUT_B = 2'd3
  } dir_e;

  localparam int MODE_W = 2;
endpackage

// File: rtl/pio_in_path.sv
module pio_in_path
  import pio_pkg::*;
(
  input  logic              ioclk0,
  input  logic              ioclk1,
  input  logic              rst_n,
  input  logic              clk_sel,
  input  logic [MODE_W-1:0] in_mode,
  input  logic              pad_in,
  output logic              core_di
);
  logic io_clk;
  logic cap_q;
  logic lat_q;

  // Per-lane clock choice between the two I/O clock lines
  assign io_clk = clk_sel ? ioclk1 : ioclk0;

  always_ff @(posedge io_clk or negedge rst_n) begin
    if (!rst_n) cap_q <= 1'b0;
    else        cap_q <= pad_in;
  end

  // Transparent while the selected clock is high
  always_latch begin
    if (!rst_n)      lat_q <= 1'b0;
    else if (io_clk) lat_q <= pad_in;
  end

  always_comb begin
    case (in_mode)
      IN_REG:   core_di = cap_q;
      IN_LATCH: core_di = lat_q;
      default:  core_di = pad_in;
    endcase
  end
endmodule

// File: rtl/pio_out_path.sv
module pio_out_path
  import pio_pkg::*;
#(
  parameter int N_GOE = 2,
  parameter int SRC_W = 2
) (
  input  logic [MODE_W-1:0] dir,
  input  logic [SRC_W-1:0]  oe_src,
  input  logic              od,
  input  logic [N_GOE-1:0]  goe,
  input  logic              core_do,
  input  logic              core_oe,
  output logic              pad_out,
  output logic              pad_oe
);
  localparam int GSEL_W = (N_GOE > 1) ? $clog2(N_GOE) : 1;

  logic en;
  logic bidir_en;

  always_comb begin
    if (int'(oe_src) < N_GOE) bidir_en = goe[oe_src[GSEL_W-1:0]];
    else                      bidir_en = core_oe;
  end

  always_comb begin
    case (dir)
      DIR_OUTPUT: en = 1'b1;
      DIR_BIDIR:  en = bidir_en;
      default:    en = 1'b0;
    endcase
  end

  // Open-drain: release the pin for a high, pull low otherwise
  assign pad_out = od ? 1'b0 : core_do;
  assign pad_oe  = od ? (en & ~core_do) : en;
endmodule

// File: rtl/pio_cell_bank.sv
module pio_cell_bank
  import pio_pkg::*;
#(
  parameter int N_CELLS = 4,
  parameter int N_GOE   = 2
) (
  input  logic                      ioclk0,
  input  logic                      ioclk1,
  input  logic                      rst_n,
  input  logic [N_GOE-1:0]          goe,
  input  logic [MODE_W*N_CELLS-1:0] cfg_in_mode,
  input  logic [N_CELLS-1:0]        cfg_clk_sel,
  input  logic [MODE_W*N_CELLS-1:0] cfg_dir,
  input  logic [MODE_W*N_CELLS-1:0] cfg_oe_src,
  input  logic [N_CELLS-1:0]        cfg_od,
  input  logic [N_CELLS-1:0]        core_do,
  input  logic [N_CELLS-1:0]        core_oe,
  output logic [N_CELLS-1:0]        core_di,
  input  logic [N_CELLS-1:0]        pad_in,
  output logic [N_CELLS-1:0]        pad_out,
  output logic [N_CELLS-1:0]        pad_oe
);
  localparam int SRC_W = MODE_W;

  for (genvar i = 0; i < N_CELLS; i++) begin : g_lane
    pio_in_path u_in (
      .ioclk0  (ioclk0),
      .ioclk1  (ioclk1),
      .rst_n   (rst_n),
      .clk_sel (cfg_clk_sel[i]),
      .in_mode (cfg_in_mode[MODE_W*i +: MODE_W]),
      .pad_in  (pad_in[i]),
      .core_di (core_di[i])
    );

    pio_out_path #(.N_GOE(N_GOE), .SRC_W(SRC_W)) u_out (
      .dir     (cfg_dir[MODE_W*i +: MODE_W]),
      .oe_src  (cfg_oe_src[SRC_W*i +: SRC_W]),
      .od      (cfg_od[i]),
      .goe     (goe),
      .core_do (core_do[i]),
      .core_oe (core_oe[i]),
      .pad_out (pad_out[i]),
      .pad_oe  (pad_oe[i])
    );
  end
endmodule

// File: rtl/pio_cell_bank_chk.sv
module pio_cell_bank_chk #(
  parameter int N_CELLS = 4,
  parameter int N_GOE   = 2
) (
  input logic                   ioclk0,
  input logic                   rst_n,
  input logic [2*N_CELLS-1:0]   cfg_in_mode,
  input logic [2*N_CELLS-1:0]   cfg_dir,
  input logic [N_CELLS-1:0]     cfg_od,
  input logic [N_CELLS-1:0]     core_di,
  input logic [N_CELLS-1:0]     pad_in,
  input logic [N_CELLS-1:0]     pad_out,
  input logic [N_CELLS-1:0]     pad_oe
);
  logic [N_CELLS-1:0] m_direct, m_in_only, m_out_only;

  always_comb begin
    for (int i = 0; i < N_CELLS; i++) begin
      m_direct[i]   = (cfg_in_mode[2*i +: 2] == 2'd0) || (cfg_in_mode[2*i +: 2] == 2'd3);
      m_in_only[i]  = (cfg_dir[2*i +: 2] == 2'd0) || (cfg_dir[2*i +: 2] == 2'd3);
      m_out_only[i] = (cfg_dir[2*i +: 2] == 2'd1) && !cfg_od[i];
    end
  end

  p_od_low_only_r9: assert property (@(posedge ioclk0) disable iff (!rst_n)
    (pad_oe & pad_out & cfg_od) == '0);

  p_input_no_drive_r5: assert property (@(posedge ioclk0) disable iff (!rst_n)
    (pad_oe & m_in_only) == '0);

  p_direct_follow_r1: assert property (@(posedge ioclk0) disable iff (!rst_n)
    (core_di & m_direct) == (pad_in & m_direct));

  p_output_drives_r6: assert property (@(posedge ioclk0) disable iff (!rst_n)
    (pad_oe & m_out_only) == m_out_only);
endmodule

bind pio_cell_bank pio_cell_bank_chk #(.N_CELLS(N_CELLS), .N_GOE(N_GOE)) u_chk (.*);

// File: tb/pio_cell_bank_tb.sv
`timescale 1ns/100ps
module pio_cell_bank_tb;
  localparam int N = 4;

  logic ioclk0 = 1'b0;
  logic ioclk1 = 1'b0;
  always #2 ioclk0 = ~ioclk0;   // 250 MHz
  always #6 ioclk1 = ~ioclk1;

  logic           rst_n;
  logic [1:0]     goe;
  logic [2*N-1:0] cfg_in_mode, cfg_dir, cfg_oe_src;
  logic [N-1:0]   cfg_clk_sel, cfg_od, core_do, core_oe, core_di, pad_in, pad_out, pad_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  pio_cell_bank #(.N_CELLS(N), .N_GOE(2)) u_dut (
    .ioclk0(ioclk0), .ioclk1(ioclk1), .rst_n(rst_n), .goe(goe),
    .cfg_in_mode(cfg_in_mode), .cfg_clk_sel(cfg_clk_sel), .cfg_dir(cfg_dir),
    .cfg_oe_src(cfg_oe_src), .cfg_od(cfg_od), .core_do(core_do), .core_oe(core_oe),
    .core_di(core_di), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [2*N-1:0] rep2(input logic [1:0] v);
    return {N{v}};
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] prev;
    rst_n = 1'b0; goe = '0;
    cfg_in_mode = rep2(2'd1); cfg_dir = '0; cfg_oe_src = '0;
    cfg_clk_sel = '0; cfg_od = '0; core_do = '0; core_oe = '0; pad_in = '1;
    #1;
    chk("R4 reset clears register", core_di, '0);
    chk("R5 reset state no drive", pad_oe, '0);
    #9.5 rst_n = 1'b1;

    // R1 direct mode, both encodings
    for (int m = 0; m < 2; m++) begin
      cfg_in_mode = rep2(m == 0 ? 2'd0 : 2'd3);
      for (int v = 0; v < 16; v++) begin
        pad_in = 4'(v); #0.5;
        chk("R1 direct", core_di, 4'(v));
      end
    end

    // R2 registered on ioclk0
    cfg_in_mode = rep2(2'd1); cfg_clk_sel = '0;
    @(posedge ioclk0); #0.5; prev = pad_in;
    for (int v = 0; v < 16; v += 3) begin
      @(negedge ioclk0); pad_in = 4'(v); #0.5;
      chk("R2 hold between edges", core_di, prev);
      @(posedge ioclk0); #0.5;
      chk("R2 capture ioclk0", core_di, 4'(v));
      prev = 4'(v);
    end

    // R2 registered on ioclk1, ioclk0 edges ignored
    cfg_clk_sel = '1;
    @(posedge ioclk1); #0.5; prev = pad_in;
    for (int v = 1; v < 16; v += 5) begin
      @(negedge ioclk1); pad_in = 4'(v); #0.5;
      @(posedge ioclk0); #0.5;
      chk("R2 unselected clock ignored", core_di, prev);
      @(posedge ioclk1); #0.5;
      chk("R2 capture ioclk1", core_di, 4'(v));
      prev = 4'(v);
    end

    // R3 latched on each clock line
    cfg_in_mode = rep2(2'd2);
    for (int c = 0; c < 2; c++) begin
      cfg_clk_sel = {N{c[0]}};
      for (int v = 2; v < 16; v += 4) begin
        if (c == 0) @(posedge ioclk0); else @(posedge ioclk1);
        #0.5; pad_in = 4'(v); #0.5;
        chk("R3 transparent", core_di, 4'(v));
        if (c == 0) @(negedge ioclk0); else @(negedge ioclk1);
        #0.5; pad_in = ~4'(v); #0.5;
        chk("R3 hold while low", core_di, 4'(v));
      end
    end

    // R4 reset of register lanes (0,1) and latch lanes (2,3)
    cfg_clk_sel = '0; cfg_in_mode = {2'd2, 2'd2, 2'd1, 2'd1};
    pad_in = 4'hF;
    @(posedge ioclk0); #0.5;
    @(negedge ioclk0); #0.5;
    chk("R4 loaded before reset", core_di, 4'hF);
    rst_n = 1'b0; #0.5;
    chk("R4 immediate clear", core_di, 4'h0);
    @(posedge ioclk0); #0.5;
    chk("R4 clear holds over edge", core_di, 4'h0);
    @(negedge ioclk0); #0.5; rst_n = 1'b1;
    #0.5;
    chk("R4 latch stays cleared while clock low", core_di, 4'h0);

    // Output path sweep: R5 R6 R7 R8 R9
    for (int d = 0; d < 4; d++)
      for (int s = 0; s < 4; s++)
        for (int o = 0; o < 2; o++)
          for (int g = 0; g < 4; g++)
            for (int x = 0; x < 2; x++)
              for (int e = 0; e < 2; e++) begin
                logic en, eo, ev;
                string rq;
                cfg_dir = rep2(2'(d)); cfg_oe_src = rep2(2'(s)); cfg_od = {N{o[0]}};
                goe = 2'(g); core_do = {N{x[0]}}; core_oe = {N{e[0]}};
                #0.5;
                if (d == 1) en = 1'b1;
                else if (d == 2) en = (s == 0) ? goe[0] : (s == 1) ? goe[1] : e[0];
                else en = 1'b0;
                eo = o[0] ? (en & ~x[0]) : en;
                ev = o[0] ? 1'b0 : x[0];
                rq = o[0] ? "R9" : (d == 2) ? "R7" : (d == 1) ? "R6" : "R5";
                chk(rq, pad_oe, {N{eo}});
                chk(o[0] ? "R9 out" : "R8 out", pad_out, {N{ev}});
              end

    // R10 capture while driving
    cfg_in_mode = rep2(2'd1); cfg_clk_sel = '0; cfg_dir = rep2(2'd2);
    cfg_oe_src = rep2(2'd2); cfg_od = '0; core_oe = '1; core_do = 4'hA;
    @(negedge ioclk0); pad_in = 4'h5;
    @(posedge ioclk0); #0.5;
    chk("R10 driving", pad_oe, 4'hF);
    chk("R10 capture while driving", core_di, 4'h5);

    // R11 independent lanes
    cfg_in_mode = {2'd0, 2'd2, 2'd1, 2'd0};
    cfg_clk_sel = 4'b0100;
    cfg_dir     = {2'd2, 2'd2, 2'd1, 2'd0};
    cfg_oe_src  = {2'd2, 2'd1, 2'd0, 2'd0};
    cfg_od      = 4'b1010;
    goe = 2'b10; core_do = 4'hF; core_oe = 4'b1000;
    pad_in = 4'b1001; #0.5;
    chk("R11 lane enables", pad_oe, 4'b0100);
    chk("R11 lane data", pad_out, 4'b0101);
    chk("R11 direct lanes", core_di & 4'b1001, 4'b1001);
    pad_in = 4'b0000; #0.5;
    chk("R11 direct lanes low", core_di & 4'b1001, 4'b0000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule